// File: doc/BRIEF.md
# Per-Core DVFS Policy Engine

This block chooses an operating point for every core of a multicore chip. On a start pulse it samples one workload figure per core, either how well the workload speeds up with clock rate or how much power it draws, and turns it into a frequency code using one of three policies. A core can be sent to full speed when its figure passes a threshold. Its frequency can instead follow the figure in a straight line. The third policy inverts the power curve, which rises as a cube above nominal and linearly below it. A voltage code follows from each frequency.

After the initial choice, the engine lowers frequencies one step per cycle. It first makes sure each supply stays inside its current limit. This is done per core when every core has its own supply, or across all cores when they share one. It then lowers all active cores together until the estimated chip power fits the budget. The results hold, with `done` high, until the next start.

Top module: `dvfs_policy_engine`

## Requirements
- R1: After reset every frequency and voltage code is 0 and `done` is low.
- R2: With `policy` 0 (threshold), an active core whose selected figure x is strictly greater than `thresh` starts at frequency 200, and any other active core starts at 100.
- R3: The selected figure x is the core's scalability byte when `src_sel` is 0 and its power byte when `src_sel` is 1. When `src_sel` is 2 or 3 it is 255 minus the power byte.
- R4: With `policy` 1 (linear), an active core starts at 50 + floor(x*151/256), which spans 50..200.
- R5: With `policy` 2 or 3 (inverse power), the power target is t = 50 + floor(x*753/256). The core settles at the smallest f in 50..200 with pc(f) >= t. Here pc(f) = f for f <= 100 and floor(f^3/10000) above 100.
- R6: The voltage code of an active core is 20 for f <= 100 and floor(f/5) above 100.
- R7: With `shared_supply` low, each active core above 50 whose current floor((w+1)*ic(f)/256) exceeds `cur_cap` steps down one per cycle until it fits or reaches 50. Here w is the core's power byte, and ic(f) = f for f <= 100 and floor(f^2/100) above 100.
- R8: With `shared_supply` high, while the sum of active core currents exceeds `cur_cap`, every active core above 50 steps down one per cycle together.
- R9: After the current step, while the sum of core powers floor((w+1)*pc(f)/256) exceeds `pwr_budget` and some active core is above 50, every active core above 50 steps down one per cycle.
- R10: An inactive core reports frequency and voltage codes of 0 and adds nothing to either sum.
- R11: `done` is low in the cycle after a start and rises when the engine finishes. Inputs are sampled only at start. Outputs and `done` hold until the next start.
- R12: An active core's frequency code always lies within 50..200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an evaluation and samples all inputs |
| policy | input | 2 | 0 threshold, 1 linear, 2/3 inverse power |
| src_sel | input | 2 | Figure source: 0 scalability, 1 power, 2/3 inverted power |
| thresh | input | 8 | Threshold for policy 0 |
| shared_supply | input | 1 | 1: all cores draw from one supply |
| core_active | input | NCORES | Per-core activity flags |
| core_scal | input | NCORES*8 | Per-core scalability bytes |
| core_pwr | input | NCORES*8 | Per-core relative power bytes |
| cur_cap | input | BW | Current limit per supply |
| pwr_budget | input | BW | Chip power budget |
| freq_out | output | NCORES*8 | Per-core frequency codes, percent of nominal |
| volt_out | output | NCORES*6 | Per-core voltage codes |
| done | output | 1 | Evaluation complete, results valid |

## Verification
The bench builds the engine with NCORES = 4 and BW = 16. With four cores, 64 starts per policy cover all 256 figure codes. This makes the linear and inverse-power mappings checkable over their full input range. The small core count also keeps the shared-supply sums small enough to sweep the current and power limits from no effect down to zero, which drives every core onto the 50 floor.

// File: rtl/dvfs_policy_engine.sv
module dvfs_policy_engine #(
  parameter int NCORES = 16,
  parameter int BW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [1:0]           policy,
  input  logic [1:0]           src_sel,
  input  logic [7:0]           thresh,
  input  logic                 shared_supply,
  input  logic [NCORES-1:0]    core_active,
  input  logic [NCORES*8-1:0]  core_scal,
  input  logic [NCORES*8-1:0]  core_pwr,
  input  logic [BW-1:0]        cur_cap,
  input  logic [BW-1:0]        pwr_budget,
  output logic [NCORES*8-1:0]  freq_out,
  output logic [NCORES*6-1:0]  volt_out,
  output logic                 done
);
  localparam logic [7:0] FMIN = 8'd50;
  localparam logic [7:0] FNOM = 8'd100;
  localparam logic [7:0] FMAX = 8'd200;
  localparam logic [5:0] VMIN = 6'd20;
  localparam int SW = 10 + $clog2(NCORES + 1);
  localparam int CW = (SW > BW) ? SW : BW;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_CAP, S_NORM} st_t;

  st_t                      state;
  logic [NCORES-1:0]        act_q, grow, above, capov, dec;
  logic                     poly_q, shared_q;
  logic [BW-1:0]            cap_q, bud_q;
  logic [NCORES-1:0][9:0]   pw_c;
  logic [NCORES-1:0][8:0]   cu_c;
  logic [SW-1:0]            sum_pw, sum_cu;
  logic                     over_cap, over_bud, trimming;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    logic [7:0]  f_q, w_q, xv, lin_f, f0;
    logic [9:0]  tgt_q, tgt_v, pc;
    logic [8:0]  ic, wp1;
    logic [15:0] lin_m, f2;
    logic [17:0] tgt_m, cu_m;
    logic [18:0] pw_m;
    logic [23:0] f3;

    assign xv = (src_sel == 2'd0) ? core_scal[i*8 +: 8] :
                (src_sel == 2'd1) ? core_pwr[i*8 +: 8] : ~core_pwr[i*8 +: 8];
    assign lin_m = 16'(xv) * 16'd151;
    assign lin_f = FMIN + 8'(lin_m >> 8);
    assign tgt_m = 18'(xv) * 18'd753;
    assign tgt_v = 10'd50 + 10'(tgt_m >> 8);

    always_comb begin
      if (!core_active[i])     f0 = 8'd0;
      else if (policy == 2'd0) f0 = (xv > thresh) ? FMAX : FNOM;
      else if (policy == 2'd1) f0 = lin_f;
      else                     f0 = FMIN;
    end

    assign f3   = 24'(f_q) * 24'(f_q) * 24'(f_q);
    assign f2   = 16'(f_q) * 16'(f_q);
    assign pc   = (f_q <= FNOM) ? 10'(f_q) : 10'(f3 / 24'd10000);
    assign ic   = (f_q <= FNOM) ? 9'(f_q) : 9'(f2 / 16'd100);
    assign wp1  = 9'(w_q) + 9'd1;
    assign pw_m = 19'(wp1) * 19'(pc);
    assign cu_m = 18'(wp1) * 18'(ic);
    assign pw_c[i] = 10'(pw_m >> 8);
    assign cu_c[i] = 9'(cu_m >> 8);

    assign grow[i]  = act_q[i] && poly_q && (pc < tgt_q);
    assign above[i] = act_q[i] && (f_q > FMIN);
    assign capov[i] = CW'(cu_c[i]) > CW'(cap_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q   <= '0;
        w_q   <= '0;
        tgt_q <= '0;
      end else if (start) begin
        f_q   <= f0;
        w_q   <= core_pwr[i*8 +: 8];
        tgt_q <= tgt_v;
      end else if (state == S_INIT && grow[i]) begin
        f_q <= f_q + 8'd1;
      end else if (dec[i]) begin
        f_q <= f_q - 8'd1;
      end
    end

    assign freq_out[i*8 +: 8] = f_q;
    assign volt_out[i*6 +: 6] = (f_q == 8'd0) ? 6'd0 :
                                (f_q <= FNOM) ? VMIN : 6'(f_q / 8'd5);
  end

  always_comb begin
    sum_pw = '0;
    sum_cu = '0;
    for (int i = 0; i < NCORES; i++) begin
      sum_pw = sum_pw + SW'(pw_c[i]);
      sum_cu = sum_cu + SW'(cu_c[i]);
    end
  end

  assign over_cap = CW'(sum_cu) > CW'(cap_q);
  assign over_bud = CW'(sum_pw) > CW'(bud_q);
  assign trimming = (state == S_CAP) || (state == S_NORM);
  assign dec = above & (({NCORES{state == S_CAP}} &
                         (shared_q ? {NCORES{over_cap}} : capov)) |
                        {NCORES{state == S_NORM && over_bud}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      act_q    <= '0;
      poly_q   <= 1'b0;
      shared_q <= 1'b0;
      cap_q    <= '0;
      bud_q    <= '0;
    end else if (start) begin
      state    <= S_INIT;
      done     <= 1'b0;
      act_q    <= core_active;
      poly_q   <= policy[1];
      shared_q <= shared_supply;
      cap_q    <= cur_cap;
      bud_q    <= pwr_budget;
    end else begin
      case (state)
        S_INIT: if (!(|grow)) state <= S_CAP;
        S_CAP:  if (!(|dec))  state <= S_NORM;
        S_NORM: if (!(|dec)) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

module dvfs_policy_engine_chk #(
  parameter int NCORES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic                trimming,
  input logic [NCORES*8-1:0] freq_out,
  input logic [NCORES*6-1:0] volt_out
);
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(freq_out) && $stable(volt_out)));

  for (genvar i = 0; i < NCORES; i++) begin : g_chk
    a_r12_freq_range: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_out[i*8 +: 8] != 8'd0) |->
      (freq_out[i*8 +: 8] >= 8'd50 && freq_out[i*8 +: 8] <= 8'd200));

    a_r6_volt_range: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_out[i*8 +: 8] != 8'd0) |->
      (volt_out[i*6 +: 6] >= 6'd20 && volt_out[i*6 +: 6] <= 6'd40));

    a_r9_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (trimming && !start) |=> (freq_out[i*8 +: 8] <= $past(freq_out[i*8 +: 8])));
  end
endmodule

bind dvfs_policy_engine dvfs_policy_engine_chk #(.NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .trimming(trimming),
  .freq_out(freq_out), .volt_out(volt_out));

// File: tb/dvfs_policy_engine_test.sv
module dvfs_policy_engine_test;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] pol = '0, src = '0;
  logic [7:0] thr = '0;
  logic shr = 1'b0;
  logic [NC-1:0] act = '0;
  logic [15:0] cap = '0, bud = '0;
  logic [7:0] sc [NC];
  logic [7:0] pr [NC];
  logic [NC*8-1:0] sc_bus, pr_bus, freq;
  logic [NC*6-1:0] volt;
  logic done;
  int nvec = 0, nbad = 0;
  int ef [NC];

  always_comb
    for (int i = 0; i < NC; i++) begin
      sc_bus[i*8 +: 8] = sc[i];
      pr_bus[i*8 +: 8] = pr[i];
    end

  dvfs_policy_engine #(.NCORES(NC), .BW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .policy(pol), .src_sel(src),
    .thresh(thr), .shared_supply(shr), .core_active(act), .core_scal(sc_bus),
    .core_pwr(pr_bus), .cur_cap(cap), .pwr_budget(bud), .freq_out(freq),
    .volt_out(volt), .done(done));

  task automatic chk(input string tag, input int got, input int exp);
    nvec++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int pcf(input int f);
    return (f <= 100) ? f : f * f * f / 10000;
  endfunction
  function automatic int icf(input int f);
    return (f <= 100) ? f : f * f / 100;
  endfunction
  function automatic int vcf(input int f);
    return (f == 0) ? 0 : (f <= 100) ? 20 : f / 5;
  endfunction
  function automatic int xof(input int i);
    if (src == 2'd0) return int'(sc[i]);
    if (src == 2'd1) return int'(pr[i]);
    return 255 - int'(pr[i]);
  endfunction

  task automatic predict();
    int f [NC];
    int s, x, t;
    bit any, go;
    for (int i = 0; i < NC; i++) begin
      if (!act[i]) f[i] = 0;
      else begin
        x = xof(i);
        if (pol == 2'd0) f[i] = (x > int'(thr)) ? 200 : 100;
        else if (pol == 2'd1) f[i] = 50 + ((x * 151) >> 8);
        else begin
          t = 50 + ((x * 753) >> 8);
          f[i] = 50;
          while (pcf(f[i]) < t) f[i]++;
        end
      end
    end
    if (shr) begin
      go = 1'b1;
      while (go) begin
        s = 0; any = 1'b0;
        for (int i = 0; i < NC; i++) if (act[i]) begin
          s += ((int'(pr[i]) + 1) * icf(f[i])) >> 8;
          if (f[i] > 50) any = 1'b1;
        end
        go = (s > int'(cap)) && any;
        if (go) for (int i = 0; i < NC; i++) if (act[i] && f[i] > 50) f[i]--;
      end
    end else begin
      for (int i = 0; i < NC; i++)
        while (act[i] && f[i] > 50 && (((int'(pr[i]) + 1) * icf(f[i])) >> 8) > int'(cap)) f[i]--;
    end
    go = 1'b1;
    while (go) begin
      s = 0; any = 1'b0;
      for (int i = 0; i < NC; i++) if (act[i]) begin
        s += ((int'(pr[i]) + 1) * pcf(f[i])) >> 8;
        if (f[i] > 50) any = 1'b1;
      end
      go = (s > int'(bud)) && any;
      if (go) for (int i = 0; i < NC; i++) if (act[i] && f[i] > 50) f[i]--;
    end
    for (int i = 0; i < NC; i++) ef[i] = f[i];
  endtask

  task automatic setup(input logic [1:0] p, input logic [1:0] s, input logic [7:0] t,
                       input logic sh, input logic [NC-1:0] a, input logic [15:0] c,
                       input logic [15:0] b);
    pol = p; src = s; thr = t; shr = sh; act = a; cap = c; bud = b;
  endtask

  task automatic run(input string tag, input bit disturb);
    logic [NC-1:0] act0;
    int n;
    string ct;
    predict();
    act0 = act;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({tag, " R11 done low after start"}, int'(done), 0);
    if (disturb) begin
      pol = ~pol; src = ~src; thr = ~thr; shr = ~shr; act = ~act;
      cap = ~cap; bud = ~bud;
      for (int i = 0; i < NC; i++) begin sc[i] = ~sc[i]; pr[i] = ~pr[i]; end
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL R11 %s: got done=0 expected done=1", tag);
      return;
    end
    for (int i = 0; i < NC; i++) begin
      ct = act0[i] ? tag : "R10";
      chk($sformatf("%s core%0d freq", ct, i), int'(freq[i*8 +: 8]), ef[i]);
      chk($sformatf("R6 %s core%0d volt", ct, i), int'(volt[i*6 +: 6]), vcf(ef[i]));
      if (act0[i])
        chk($sformatf("R12 core%0d in range", i),
            int'(freq[i*8 +: 8] >= 8'd50 && freq[i*8 +: 8] <= 8'd200), 1);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL R11 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin sc[i] = '0; pr[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 freq after reset", int'(freq != '0), 0);
    chk("R1 volt after reset", int'(volt != '0), 0);
    chk("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 3; p++)
      for (int b = 0; b < 64; b++) begin
        setup(2'(p), 2'd0, 8'd137, 1'b0, '1, 16'hFFFF, 16'hFFFF);
        for (int i = 0; i < NC; i++) begin sc[i] = 8'(b * 4 + i); pr[i] = 8'd255; end
        run(p == 0 ? "R2" : p == 1 ? "R4" : "R5", 1'b0);
      end

    for (int s = 1; s < 4; s++)
      for (int b = 0; b < 16; b++) begin
        setup(2'd1, 2'(s), 8'd0, 1'b0, '1, 16'hFFFF, 16'hFFFF);
        for (int i = 0; i < NC; i++) begin
          pr[i] = 8'(b * 16 + i * 5);
          sc[i] = 8'(int'(pr[i]) * 7 + 13);
        end
        run("R3", 1'b0);
      end

    foreach (ef[k]) ef[k] = 0;
    for (int k = 0; k < 5; k++) begin
      int tv;
      tv = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 100 : (k == 3) ? 254 : 255;
      setup(2'd0, 2'd0, 8'(tv), 1'b0, '1, 16'hFFFF, 16'hFFFF);
      sc[0] = 8'(tv - 1); sc[1] = 8'(tv); sc[2] = 8'(tv + 1); sc[3] = 8'd255;
      for (int i = 0; i < NC; i++) pr[i] = 8'd255;
      run("R2", 1'b0);
    end

    for (int m = 0; m < 16; m++) begin
      setup(2'd1, 2'd0, 8'd0, 1'b0, NC'(m), 16'hFFFF, 16'd900);
      for (int i = 0; i < NC; i++) begin sc[i] = 8'(60 * i + 20); pr[i] = 8'd200; end
      run("R9", 1'b0);
    end

    for (int k = 0; k < 8; k++) begin
      int cv [8] = '{500, 400, 300, 200, 120, 60, 20, 0};
      setup(2'd0, 2'd0, 8'd0, 1'b0, '1, 16'(cv[k]), 16'hFFFF);
      pr[0] = 8'd255; pr[1] = 8'd128; pr[2] = 8'd60; pr[3] = 8'd10;
      for (int i = 0; i < NC; i++) sc[i] = 8'd255;
      run("R7", 1'b0);
    end

    for (int k = 0; k < 6; k++) begin
      int cv [6] = '{1000, 600, 400, 250, 100, 0};
      setup(2'd0, 2'd0, 8'd0, 1'b1, '1, 16'(cv[k]), 16'hFFFF);
      pr[0] = 8'd255; pr[1] = 8'd128; pr[2] = 8'd60; pr[3] = 8'd10;
      for (int i = 0; i < NC; i++) sc[i] = 8'd255;
      run("R8", 1'b0);
    end

    for (int p = 1; p < 3; p++)
      for (int k = 0; k < 8; k++) begin
        int bv [8] = '{4000, 2000, 1200, 700, 400, 250, 150, 0};
        setup(2'(p), 2'd0, 8'd0, 1'b0, '1, 16'hFFFF, 16'(bv[k]));
        sc[0] = 8'd255; sc[1] = 8'd200; sc[2] = 8'd90; sc[3] = 8'd30;
        for (int i = 0; i < NC; i++) pr[i] = 8'd255;
        run("R9", 1'b0);
      end

    setup(2'd2, 2'd0, 8'd0, 1'b0, 4'b1011, 16'd300, 16'd900);
    sc[0] = 8'd240; sc[1] = 8'd70; sc[2] = 8'd180; sc[3] = 8'd10;
    pr[0] = 8'd255; pr[1] = 8'd90; pr[2] = 8'd40; pr[3] = 8'd200;
    run("R11", 1'b1);
    pol = 2'd0; thr = 8'd0; act = '1; cap = 16'hFFFF; bud = 16'hFFFF;
    for (int i = 0; i < NC; i++) begin sc[i] = 8'd255; pr[i] = 8'd3; end
    repeat (25) @(negedge clk);
    chk("R11 done held", int'(done), 1);
    for (int i = 0; i < NC; i++)
      chk($sformatf("R11 core%0d freq held", i), int'(freq[i*8 +: 8]), ef[i]);

    summary();
    $finish;
  end
endmodule